// File: doc/BRIEF.md
# Memory Access Watchpoint Unit

This block sits beside a shared-memory arbiter and watches every access the arbiter grants. It has four independent watchpoint channels. Each channel is programmed with an inclusive address window, a set of access kinds (read, write) and a set of requesting clients. An access that meets all three conditions makes the channel record what it saw and raise an interrupt request toward the processor.

Each channel keeps one frozen capture record: the clients that matched, the lowest-numbered matching client, the address, the access kind and the size. The record stays untouched until software re-arms that channel, so the first offending access is never overwritten. Pending requests are gated by a global enable mask. The resulting masked bits are ORed onto a single interrupt line, and software clears them through a write-one-to-clear register. Everything is reached through a word-addressed register port whose reads return data in the same cycle.

The register address has eight bits: the upper nibble picks a page and the lower nibble picks a register. Pages 0 to 3 are the channels and page 0xF holds the global registers.

Top module: `mem_watch_unit`

## Requirements
- R1: After reset every configuration register, capture register, the enable mask and the pending bits read 0, a channel reads as armed (re-arm register reads 0) and `irq` is low.
- R2: An access can hit a channel only when `acc_valid` is 1 and first ≤ address ≤ last, compared unsigned, with both bounds included. Within a channel page, offset 0 is the first address and offset 1 is the last address.
- R3: A hit needs at least one bit set in both `acc_op` and the channel's kind mask (offset 2). Bit 0 of each means read and bit 1 means write.
- R4: A hit needs at least one client present in both `acc_clients` and the channel's client mask (offset 3). The captured client set (offset 4) is their AND, and the captured first client (offset 7) is the lowest index in that AND.
- R5: On a hit by an armed channel, the channel stores the address at offset 5, the `acc_op` value as presented at offset 6 and `acc_size` at offset 8. All of these can be read in the cycle after the access.
- R6: Once a channel has captured, it ignores further hits and leaves its record unchanged until software writes any value to its re-arm register (offset 9). Reading offset 9 returns 1 while the channel holds a capture.
- R7: A capture sets that channel's bit in the raw pending register (page 0xF, offset 3) whatever the mask says. Offset 1 reads pending AND enable mask (offset 0), and `irq` is high exactly when that masked value is nonzero.
- R8: Writing to the acknowledge register (page 0xF, offset 2) clears each pending bit written as 1 and leaves bits written as 0 alone. A capture in the same cycle as its acknowledge leaves the bit set.
- R9: Re-arming a channel does not clear its pending bit.
- R10: Channels act independently. One access that matches several channels is captured by each of them in the same cycle, and a channel that does not match is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address: page in bits 7:4, offset in bits 3:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| acc_valid | input | 1 | A granted access is present this cycle |
| acc_addr | input | 32 | Address of the granted access |
| acc_op | input | 2 | Access kind: bit 0 read, bit 1 write |
| acc_clients | input | 14 | One bit for each client taking part in the access |
| acc_size | input | 3 | Size code of the access |
| irq | output | 1 | OR of the masked pending bits |

## Verification
The bench goes after both window edges and the addresses one below and one above them. A design that used strict comparison or signed comparison would miss the edges or catch the neighbours. It offers client sets in which several clients match and some do not. A wrong priority encoder would report the wrong first client, and storing the raw set instead of the AND would report foreign clients. It sends a second hit into a captured channel, and a design without the freeze would overwrite the first record. It also lands a capture and its acknowledge on the same edge, where a design with clear-over-set priority would lose the event. Acknowledge writes with zero bits, and re-arms that must leave pending bits in place, expose designs that clear too much.

// File: rtl/mwu_pkg.sv
package mwu_pkg;
   localparam int PAGE_W = 4;
   localparam int OFF_W  = 4;
   localparam int REG_AW = PAGE_W + OFF_W;

   localparam logic [OFF_W-1:0] OFF_FIRST  = 4'd0;
   localparam logic [OFF_W-1:0] OFF_LAST   = 4'd1;
   localparam logic [OFF_W-1:0] OFF_KINDS  = 4'd2;
   localparam logic [OFF_W-1:0] OFF_CLIM   = 4'd3;
   localparam logic [OFF_W-1:0] OFF_CCLI   = 4'd4;
   localparam logic [OFF_W-1:0] OFF_CADDR  = 4'd5;
   localparam logic [OFF_W-1:0] OFF_CKIND  = 4'd6;
   localparam logic [OFF_W-1:0] OFF_CFIRST = 4'd7;
   localparam logic [OFF_W-1:0] OFF_CSIZE  = 4'd8;
   localparam logic [OFF_W-1:0] OFF_REARM  = 4'd9;

   localparam logic [PAGE_W-1:0] PAGE_GLOBAL = 4'hF;
   localparam logic [OFF_W-1:0]  OFF_ENMASK  = 4'd0;
   localparam logic [OFF_W-1:0]  OFF_MSTAT   = 4'd1;
   localparam logic [OFF_W-1:0]  OFF_ACK     = 4'd2;
   localparam logic [OFF_W-1:0]  OFF_RAW     = 4'd3;
endpackage

// File: rtl/mwu_channel.sv
module mwu_channel
   import mwu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int KIND_W = 2,
   parameter int NCLI   = 14,
   parameter int SIZE_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [OFF_W-1:0]  cfg_off,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [KIND_W-1:0] acc_op,
   input  logic [NCLI-1:0]   acc_clients,
   input  logic [SIZE_W-1:0] acc_size,
   output logic              new_capture
);
   localparam int IDX_W = (NCLI > 1) ? $clog2(NCLI) : 1;

   logic [ADDR_W-1:0] first_q, last_q, cap_addr_q;
   logic [KIND_W-1:0] kinds_q, cap_kind_q;
   logic [NCLI-1:0]   clim_q, cap_cli_q;
   logic [IDX_W-1:0]  cap_first_q, first_idx;
   logic [SIZE_W-1:0] cap_size_q;
   logic              held_q;

   logic [NCLI-1:0] cli_and;
   logic            in_window, kind_ok, hit, rearm;

   assign cli_and   = acc_clients & clim_q;
   assign in_window = (acc_addr >= first_q) && (acc_addr <= last_q);
   assign kind_ok   = |(acc_op & kinds_q);
   assign hit       = acc_valid && in_window && kind_ok && (|cli_and);
   assign new_capture = hit && !held_q;
   assign rearm     = cfg_we && (cfg_off == OFF_REARM);

   always_comb begin
      first_idx = '0;
      for (int i = NCLI - 1; i >= 0; i--) begin
         if (cli_and[i]) first_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
         kinds_q <= '0;
         clim_q  <= '0;
      end else if (cfg_we) begin
         case (cfg_off)
            OFF_FIRST: first_q <= cfg_wdata[ADDR_W-1:0];
            OFF_LAST:  last_q  <= cfg_wdata[ADDR_W-1:0];
            OFF_KINDS: kinds_q <= cfg_wdata[KIND_W-1:0];
            OFF_CLIM:  clim_q  <= cfg_wdata[NCLI-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q      <= 1'b0;
         cap_addr_q  <= '0;
         cap_kind_q  <= '0;
         cap_cli_q   <= '0;
         cap_first_q <= '0;
         cap_size_q  <= '0;
      end else if (new_capture) begin
         held_q      <= 1'b1;
         cap_addr_q  <= acc_addr;
         cap_kind_q  <= acc_op;
         cap_cli_q   <= cli_and;
         cap_first_q <= first_idx;
         cap_size_q  <= acc_size;
      end else if (rearm) begin
         held_q <= 1'b0;
      end
   end

   always_comb begin
      case (rd_off)
         OFF_FIRST:  rd_data = DATA_W'(first_q);
         OFF_LAST:   rd_data = DATA_W'(last_q);
         OFF_KINDS:  rd_data = DATA_W'(kinds_q);
         OFF_CLIM:   rd_data = DATA_W'(clim_q);
         OFF_CCLI:   rd_data = DATA_W'(cap_cli_q);
         OFF_CADDR:  rd_data = DATA_W'(cap_addr_q);
         OFF_CKIND:  rd_data = DATA_W'(cap_kind_q);
         OFF_CFIRST: rd_data = DATA_W'(cap_first_q);
         OFF_CSIZE:  rd_data = DATA_W'(cap_size_q);
         OFF_REARM:  rd_data = DATA_W'(held_q);
         default:    rd_data = '0;
      endcase
   end

   // R6: a held record does not move unless re-armed
   p_record_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && !rearm) |=> ($stable(cap_addr_q) && $stable(cap_cli_q) && held_q));

   // R2: a fresh capture lies inside the window configured at that edge
   p_capture_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held_q) |-> (cap_addr_q >= $past(first_q) && cap_addr_q <= $past(last_q)));

   // R4: the reported first client belongs to the captured set
   p_first_in_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      held_q |-> cap_cli_q[cap_first_q]);
endmodule

// File: rtl/mwu_irq.sv
module mwu_irq #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set_i,
   input  logic           mask_we,
   input  logic [NCH-1:0] mask_wdata,
   input  logic           ack_we,
   input  logic [NCH-1:0] ack_bits,
   output logic [NCH-1:0] mask_o,
   output logic [NCH-1:0] pend_o,
   output logic [NCH-1:0] stat_o,
   output logic           irq_o
);
   logic [NCH-1:0] mask_q, pend_q, clr;

   assign clr = ack_we ? ack_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         pend_q <= '0;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         pend_q <= (pend_q & ~clr) | set_i;
      end
   end

   assign mask_o = mask_q;
   assign pend_o = pend_q;
   assign stat_o = pend_q & mask_q;
   assign irq_o  = |stat_o;

   // R8: acknowledged bits without a new capture are gone next cycle
   p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ((ack_bits & ~set_i) != '0)) |=> ((pend_q & $past(ack_bits & ~set_i)) == '0));

   // R8: a capture always leaves its pending bit set
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/mem_watch_unit.sv
module mem_watch_unit
   import mwu_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 32,
   parameter int KIND_W = 2,
   parameter int NCLI   = 14,
   parameter int SIZE_W = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [KIND_W-1:0] acc_op,
   input  logic [NCLI-1:0]   acc_clients,
   input  logic [SIZE_W-1:0] acc_size,
   output logic              irq
);
   if (NUM_CH < 1 || NUM_CH > 15) begin : g_bad_nch
      $error("NUM_CH must lie in 1..15");
   end
   if (ADDR_W > DATA_W || NCLI > DATA_W || NUM_CH > DATA_W) begin : g_bad_width
      $error("fields must fit the data word");
   end

   logic [PAGE_W-1:0] page;
   logic [OFF_W-1:0]  off;
   logic [NUM_CH-1:0] cap_set, mask, pend, stat;
   logic [DATA_W-1:0] ch_rd [NUM_CH];
   logic              glob_sel;

   assign page     = reg_addr[REG_AW-1:OFF_W];
   assign off      = reg_addr[OFF_W-1:0];
   assign glob_sel = (page == PAGE_GLOBAL);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mwu_channel #(
         .ADDR_W(ADDR_W), .KIND_W(KIND_W), .NCLI(NCLI),
         .SIZE_W(SIZE_W), .DATA_W(DATA_W)
      ) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_we     (reg_we && (page == PAGE_W'(c))),
         .cfg_off    (off),
         .cfg_wdata  (reg_wdata),
         .rd_off     (off),
         .rd_data    (ch_rd[c]),
         .acc_valid  (acc_valid),
         .acc_addr   (acc_addr),
         .acc_op     (acc_op),
         .acc_clients(acc_clients),
         .acc_size   (acc_size),
         .new_capture(cap_set[c])
      );
   end

   mwu_irq #(.NCH(NUM_CH)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (cap_set),
      .mask_we   (reg_we && glob_sel && (off == OFF_ENMASK)),
      .mask_wdata(reg_wdata[NUM_CH-1:0]),
      .ack_we    (reg_we && glob_sel && (off == OFF_ACK)),
      .ack_bits  (reg_wdata[NUM_CH-1:0]),
      .mask_o    (mask),
      .pend_o    (pend),
      .stat_o    (stat),
      .irq_o     (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (glob_sel) begin
         case (off)
            OFF_ENMASK: reg_rdata = DATA_W'(mask);
            OFF_MSTAT:  reg_rdata = DATA_W'(stat);
            OFF_RAW:    reg_rdata = DATA_W'(pend);
            default:    reg_rdata = '0;
         endcase
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (page == PAGE_W'(c)) reg_rdata = ch_rd[c];
         end
      end
   end

   // R7: the interrupt line is never raised without a pending channel
   p_irq_needs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|pend));

   // R7: a capture shows up as pending on the following cycle
   p_capture_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_set != '0) |=> ((pend & $past(cap_set)) != '0));
endmodule

// File: tb/tb_mem_watch_unit.sv
module tb_mem_watch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_op = '0;
   logic [13:0] acc_clients = '0;
   logic [2:0]  acc_size = '0;
   logic        irq;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   mem_watch_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_op(acc_op), .acc_clients(acc_clients),
      .acc_size(acc_size), .irq(irq)
   );

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  op;
      logic [13:0] cli;
      logic [2:0]  size;
      logic        hit;
      logic [13:0] ecli;
      logic [3:0]  efirst;
   } vec_t;

   // channel 0: window 0x1000..0x1FFF, write only, clients 4 and 5
   localparam vec_t VECS [8] = '{
      '{32'h0000_1000, 2'b10, 14'h0010, 3'd4, 1'b1, 14'h0010, 4'd4},  // R2 low edge
      '{32'h0000_1FFF, 2'b10, 14'h0020, 3'd2, 1'b1, 14'h0020, 4'd5},  // R2 high edge
      '{32'h0000_0FFF, 2'b10, 14'h0010, 3'd1, 1'b0, 14'h0000, 4'd0},  // R2 below
      '{32'h0000_2000, 2'b10, 14'h0010, 3'd1, 1'b0, 14'h0000, 4'd0},  // R2 above
      '{32'h0000_1500, 2'b01, 14'h0010, 3'd1, 1'b0, 14'h0000, 4'd0},  // R3 read only
      '{32'h0000_1500, 2'b10, 14'h0001, 3'd1, 1'b0, 14'h0000, 4'd0},  // R4 foreign client
      '{32'h0000_1500, 2'b10, 14'h0031, 3'd3, 1'b1, 14'h0030, 4'd4},  // R4 mixed set
      '{32'h0000_1500, 2'b11, 14'h2020, 3'd7, 1'b1, 14'h0020, 4'd5}   // R3/R4 both kinds
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic access(input logic v, input logic [31:0] a, input logic [1:0] op,
                         input logic [13:0] cl, input logic [2:0] sz);
      @(negedge clk);
      acc_valid = v; acc_addr = a; acc_op = op; acc_clients = cl; acc_size = sz;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, r); chk("R1 first addr", r, 0);
      rd(8'h03, r); chk("R1 client mask", r, 0);
      rd(8'h05, r); chk("R1 capture addr", r, 0);
      rd(8'h09, r); chk("R1 armed", r, 0);
      rd(8'hF0, r); chk("R1 enable mask", r, 0);
      rd(8'hF3, r); chk("R1 pending", r, 0);
      chk("R1 irq", {31'd0, irq}, 0);

      wr(8'h00, 32'h1000);
      wr(8'h01, 32'h1FFF);
      wr(8'h02, 32'h2);
      wr(8'h03, 32'h30);

      for (int i = 0; i < 8; i++) begin
         wr(8'h09, 0);
         wr(8'hF2, 32'hF);
         access(1'b1, VECS[i].addr, VECS[i].op, VECS[i].cli, VECS[i].size);
         rd(8'hF3, r); chk($sformatf("R2 R3 R4 hit vec%0d", i), r, {31'd0, VECS[i].hit});
         if (VECS[i].hit) begin
            rd(8'h04, r); chk($sformatf("R4 clients vec%0d", i), r, {18'd0, VECS[i].ecli});
            rd(8'h07, r); chk($sformatf("R4 first vec%0d", i), r, {28'd0, VECS[i].efirst});
            rd(8'h05, r); chk($sformatf("R5 addr vec%0d", i), r, VECS[i].addr);
            rd(8'h06, r); chk($sformatf("R5 kind vec%0d", i), r, {30'd0, VECS[i].op});
            rd(8'h08, r); chk($sformatf("R5 size vec%0d", i), r, {29'd0, VECS[i].size});
         end
      end

      // R6 held record ignores a second hit
      wr(8'hF2, 32'h1);
      access(1'b1, 32'h1600, 2'b10, 14'h0010, 3'd1);
      rd(8'hF3, r); chk("R6 no new pending", r, 0);
      rd(8'h05, r); chk("R6 record kept", r, 32'h1500);
      rd(8'h09, r); chk("R6 held flag", r, 1);
      wr(8'h09, 0);
      rd(8'h09, r); chk("R6 rearmed", r, 0);
      access(1'b1, 32'h1600, 2'b10, 14'h0010, 3'd1);
      rd(8'hF3, r); chk("R6 new capture pending", r, 1);
      rd(8'h05, r); chk("R6 new record", r, 32'h1600);

      // R7 masking
      chk("R7 irq masked off", {31'd0, irq}, 0);
      rd(8'hF1, r); chk("R7 status masked off", r, 0);
      wr(8'hF0, 32'h1);
      #1 chk("R7 irq on", {31'd0, irq}, 1);
      rd(8'hF1, r); chk("R7 status on", r, 1);
      wr(8'hF0, 32'h2);
      #1 chk("R7 other mask bit", {31'd0, irq}, 0);
      wr(8'hF0, 32'h1);

      // R9 re-arm keeps pending
      wr(8'h09, 0);
      rd(8'hF3, r); chk("R9 pending after rearm", r, 1);

      // R8 acknowledge
      wr(8'hF2, 32'h0);
      rd(8'hF3, r); chk("R8 zero ack ignored", r, 1);
      wr(8'hF2, 32'h1);
      rd(8'hF3, r); chk("R8 ack clears", r, 0);
      chk("R8 irq drops", {31'd0, irq}, 0);

      // R8 capture and acknowledge on the same edge
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = 32'h1234; acc_op = 2'b10; acc_clients = 14'h0010;
      reg_we = 1'b1; reg_addr = 8'hF2; reg_wdata = 32'h1;
      @(negedge clk);
      acc_valid = 1'b0; reg_we = 1'b0;
      rd(8'hF3, r); chk("R8 set wins", r, 1);
      chk("R8 irq on set", {31'd0, irq}, 1);

      // R2 valid low never hits
      wr(8'h09, 0);
      wr(8'hF2, 32'hF);
      access(1'b0, 32'h1500, 2'b10, 14'h0010, 3'd1);
      rd(8'hF3, r); chk("R2 valid low", r, 0);
      rd(8'h09, r); chk("R2 still armed", r, 0);

      // R10 several channels on one access
      wr(8'h10, 32'h4000); wr(8'h11, 32'h40FF); wr(8'h12, 32'h3); wr(8'h13, 32'h3FFF);
      wr(8'h20, 32'h4000); wr(8'h21, 32'h40FF); wr(8'h22, 32'h2); wr(8'h23, 32'h2000);
      wr(8'h30, 32'h4000); wr(8'h31, 32'h40FF); wr(8'h32, 32'h1); wr(8'h33, 32'h3FFF);
      access(1'b1, 32'h4080, 2'b10, 14'h2000, 3'd5);
      rd(8'hF3, r); chk("R10 pending set", r, 32'h6);
      rd(8'h17, r); chk("R10 ch1 first", r, 13);
      rd(8'h25, r); chk("R10 ch2 addr", r, 32'h4080);
      rd(8'h39, r); chk("R10 ch3 untouched", r, 0);
      rd(8'h09, r); chk("R10 ch0 untouched", r, 0);
      wr(8'hF2, 32'h2);
      rd(8'hF3, r); chk("R8 per-bit ack", r, 32'h4);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule